// File: doc/BRIEF.md
# Multi-channel down-counting timer

This block holds a parameterised number of independent timer channels behind a plain 32-bit register bus. The bus has a write strobe, a read strobe, an address, write data and registered read data. Each channel owns a control word, a 64-bit interval split into two 32-bit words, and a live 64-bit count. Software writes the interval, then sets enable and reload in one write. The channel copies the interval into its counter and then counts down by one on every prescaled tick. When the count expires, the channel sets its pending flag.

In periodic mode the channel reloads the interval on expiry and keeps running. In one-shot mode it parks at zero and clears its own enable bit. One register gates which pending flags reach the per-channel interrupt outputs. A second register holds the pending flags, which are cleared by writing ones. A disabled channel ignores a re-enable that arrives too soon after the disable, which gives the stop a short settling window. Reading a count low word latches the matching high word, so two 32-bit reads return a consistent 64-bit value.

Top module: `ctmr_top`

## Requirements
- R1: After reset every register reads as zero, `irq` is all zero and `bus_rdata` is zero.
- R2: Address map: 0x00 interrupt enable (bit n for channel n), 0x04 pending status. Channel n has control at 0x20*n+0x10, interval low at +0x14, interval high at +0x18, count low at +0x1C and count high at +0x20. Read data appears on `bus_rdata` in the cycle after `bus_rd`. Unmapped addresses read zero.
- R3: Control word layout: bit 0 enable, bit 1 reload request, bits 6:4 prescale select P, bit 7 one-shot (0 = periodic). All other bits read as zero.
- R4: A running channel decrements its count by one on each tick. A tick occurs once every 2^P clock cycles, with P from 0 to 7.
- R5: Given interval N of at least 1, the channel expires on its N-th tick after the load and sets its pending bit. When the control write is accepted at clock edge t0, the pending bit is set at edge t0+1+N*2^P, and the channel's `irq` bit, if enabled, goes high at edge t0+2+N*2^P.
- R6: In periodic mode, expiry reloads the interval and counting continues without a gap, so the next expiry falls exactly N*2^P cycles later.
- R7: In one-shot mode, expiry leaves the count at zero and clears the enable bit, and no further expiry follows.
- R8: A write that sets the reload bit copies the full 64-bit interval into the counter on the next edge. The reload bit then clears itself. Rewriting the interval registers alone does not change the count.
- R9: Once a channel's enable has cleared, a write that sets enable in either of the next two cycles is ignored and enable stays 0. A write in the third cycle is accepted.
- R10: Writing a 1 to a status bit clears that bit and writing a 0 leaves it unchanged. If an expiry occurs in the same cycle as the clear, the bit stays set.
- R11: `irq[n]` is the registered AND of status bit n and enable bit n, so it lags either bit by one cycle.
- R12: A read of count low latches the current count high word. A subsequent read of count high returns that latched word, even if the live count has since borrowed across the 32-bit boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| irq | output | NCH | Per-channel interrupt, level |

## Verification
The embedded properties check these rules on every cycle:
- the count steps down by exactly one on a tick away from expiry;
- a reload copies the interval and the reload bit then clears;
- a one-shot expiry drops enable;
- enable never rises while the stop window is open;
- a clear with no concurrent expiry empties the status bit, while an expiry always leaves it set;
- an interrupt only rises when its enable was set.

Only the bench scenarios can show the end-to-end behaviour:
- the absolute expiry cycle for a given interval and prescale;
- the spacing between periodic expiries;
- the address map and the control field layout;
- the boundary cases of the stop window;
- the consistency of a 64-bit count read across a borrow from the high word.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

  localparam int REG_W = 32;
  localparam int PRE_W = 3;

  typedef struct packed {
    logic             oneshot;
    logic [PRE_W-1:0] pre;
    logic             reload;
    logic             en;
  } ctrl_t;

  // bit 7 one-shot, 6:4 prescale, 1 reload, 0 enable
  function automatic logic [REG_W-1:0] ctrl_to_word(input ctrl_t c);
    return {24'd0, c.oneshot, c.pre, 2'b00, c.reload, c.en};
  endfunction

  function automatic ctrl_t word_to_ctrl(input logic [REG_W-1:0] w);
    ctrl_t c;
    c.oneshot = w[7];
    c.pre     = w[6:4];
    c.reload  = w[1];
    c.en      = w[0];
    return c;
  endfunction

endpackage

// File: rtl/ctmr_tick_div.sv
module ctmr_tick_div #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PRE_W-1:0] pre,
  output logic             tick
);
  localparam int DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    for (int b = 0; b < DIV_W; b++) mask[b] = (b < int'(pre));
  end

  assign tick = run && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || !run) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  // R4: with prescale 0 a running channel ticks every cycle
  a_r4_full_rate: assert property (@(posedge clk) disable iff (rst)
    (run && pre == '0) |-> tick);

endmodule

// File: rtl/ctmr_channel.sv
module ctmr_channel import ctmr_pkg::*; #(
  parameter int STOP_CYC = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_ctrl,
  input  logic                 wr_ilo,
  input  logic                 wr_ihi,
  input  logic [REG_W-1:0]     wdata,
  output ctrl_t                ctrl,
  output logic [2*REG_W-1:0]   ivl,
  output logic [2*REG_W-1:0]   cnt,
  output logic                 expire
);
  localparam int CNT_W  = 2 * REG_W;
  localparam int HOLD_W = $clog2(STOP_CYC + 1);

  ctrl_t              ctrl_q, ctrl_d, wr_val;
  logic [CNT_W-1:0]   ivl_q, cnt_q;
  logic [HOLD_W-1:0]  hold_q;
  logic               run, tick, at_end;

  assign wr_val = word_to_ctrl(wdata);
  assign run    = ctrl_q.en && !ctrl_q.reload;
  assign at_end = (cnt_q <= CNT_W'(1));
  assign expire = run && tick && at_end;

  ctmr_tick_div #(.PRE_W(PRE_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .pre  (ctrl_q.pre),
    .tick (tick)
  );

  always_comb begin
    ctrl_d        = ctrl_q;
    ctrl_d.reload = 1'b0;
    if (expire && ctrl_q.oneshot) ctrl_d.en = 1'b0;
    if (wr_ctrl) begin
      ctrl_d.oneshot = wr_val.oneshot;
      ctrl_d.pre     = wr_val.pre;
      if (hold_q == '0) begin
        ctrl_d.en     = wr_val.en;
        ctrl_d.reload = wr_val.reload;
      end else begin
        ctrl_d.en     = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      ivl_q  <= '0;
      cnt_q  <= '0;
      hold_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (wr_ilo) ivl_q[REG_W-1:0]     <= wdata;
      if (wr_ihi) ivl_q[CNT_W-1:REG_W] <= wdata;
      if (ctrl_q.reload)     cnt_q <= ivl_q;
      else if (expire)       cnt_q <= ctrl_q.oneshot ? '0 : ivl_q;
      else if (run && tick)  cnt_q <= cnt_q - 1'b1;
      if (ctrl_q.en && !ctrl_d.en)  hold_q <= HOLD_W'(STOP_CYC);
      else if (hold_q != '0)        hold_q <= hold_q - 1'b1;
    end
  end

  assign ctrl = ctrl_q;
  assign ivl  = ivl_q;
  assign cnt  = cnt_q;

  // R4: one step down per tick away from expiry
  a_r4_step: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !at_end) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R7: one-shot expiry drops enable
  a_r7_oneshot_stop: assert property (@(posedge clk) disable iff (rst)
    (expire && ctrl_q.oneshot && !wr_ctrl) |=> !ctrl_q.en);

  // R8: reload copies the interval and clears itself
  a_r8_load: assert property (@(posedge clk) disable iff (rst)
    ctrl_q.reload |=> (cnt_q == $past(ivl_q)));
  a_r8_reload_clear: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.reload && !wr_ctrl) |=> !ctrl_q.reload);

  // R9: enable cannot rise inside the stop window
  a_r9_holdoff: assert property (@(posedge clk) disable iff (rst)
    (hold_q != '0) |=> !$rose(ctrl_q.en));

endmodule

// File: rtl/ctmr_top.sv
module ctmr_top import ctmr_pkg::*; #(
  parameter int NCH      = 2,
  parameter int ADDR_W   = 8,
  parameter int STOP_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCH-1:0]    irq
);
  localparam int CNT_W = 2 * REG_W;
  localparam logic [ADDR_W-1:0] A_IE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(4);

  logic [NCH-1:0]   ie_q, st_q, irq_q, st_clr, expire;
  logic [NCH-1:0]   hit_ctl, hit_ilo, hit_ihi, hit_clo, hit_chi;
  ctrl_t            ch_ctrl [NCH];
  logic [REG_W-1:0] ctl_w   [NCH];
  logic [CNT_W-1:0] ivl_w   [NCH];
  logic [CNT_W-1:0] cnt_w   [NCH];
  logic [REG_W-1:0] shadow_q[NCH];
  logic [REG_W-1:0] rd_val, rdata_q;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int BASE = 32 * i + 16;
    assign hit_ctl[i] = (bus_addr == ADDR_W'(BASE));
    assign hit_ilo[i] = (bus_addr == ADDR_W'(BASE + 4));
    assign hit_ihi[i] = (bus_addr == ADDR_W'(BASE + 8));
    assign hit_clo[i] = (bus_addr == ADDR_W'(BASE + 12));
    assign hit_chi[i] = (bus_addr == ADDR_W'(BASE + 16));

    ctmr_channel #(.STOP_CYC(STOP_CYC)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .wr_ctrl (bus_wr && hit_ctl[i]),
      .wr_ilo  (bus_wr && hit_ilo[i]),
      .wr_ihi  (bus_wr && hit_ihi[i]),
      .wdata   (bus_wdata),
      .ctrl    (ch_ctrl[i]),
      .ivl     (ivl_w[i]),
      .cnt     (cnt_w[i]),
      .expire  (expire[i])
    );
    assign ctl_w[i] = ctrl_to_word(ch_ctrl[i]);

    always_ff @(posedge clk) begin
      if (rst)                      shadow_q[i] <= '0;
      else if (bus_rd && hit_clo[i]) shadow_q[i] <= cnt_w[i][CNT_W-1:REG_W];
    end

    // R10: a clear with no concurrent expiry empties the bit
    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
      (st_clr[i] && !expire[i]) |=> !st_q[i]);
    // R10: an expiry always leaves the bit set
    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
      expire[i] |=> st_q[i]);
    // R11: interrupt only rises with its enable set
    a_r11_irq_en: assert property (@(posedge clk) disable iff (rst)
      $rose(irq[i]) |-> $past(ie_q[i]));
    a_r11_irq_follow: assert property (@(posedge clk) disable iff (rst)
      (st_q[i] && ie_q[i]) |=> irq[i]);
  end

  assign st_clr = (bus_wr && bus_addr == A_ST) ? bus_wdata[NCH-1:0] : '0;

  always_comb begin
    rd_val = '0;
    if (bus_addr == A_IE) rd_val[NCH-1:0] = ie_q;
    if (bus_addr == A_ST) rd_val[NCH-1:0] = st_q;
    for (int k = 0; k < NCH; k++) begin
      if (hit_ctl[k]) rd_val = ctl_w[k];
      if (hit_ilo[k]) rd_val = ivl_w[k][REG_W-1:0];
      if (hit_ihi[k]) rd_val = ivl_w[k][CNT_W-1:REG_W];
      if (hit_clo[k]) rd_val = cnt_w[k][REG_W-1:0];
      if (hit_chi[k]) rd_val = shadow_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q    <= '0;
      st_q    <= '0;
      irq_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (bus_wr && bus_addr == A_IE) ie_q <= bus_wdata[NCH-1:0];
      st_q  <= (st_q & ~st_clr) | expire;
      irq_q <= st_q & ie_q;
      if (bus_rd) rdata_q <= rd_val;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;

endmodule

// File: tb/ctmr_top_tb_top.sv
module ctmr_top_tb_top;
  localparam int CLK_P = 10;
  localparam int NCH   = 4;

  logic clk = 1'b0, rst = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr  = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] irq;
  int unsigned ncyc = 0;
  int total = 0, bad = 0;
  bit done = 1'b0;

  ctmr_top #(.NCH(NCH), .ADDR_W(8), .STOP_CYC(2)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) ncyc <= ncyc + 1;

  localparam logic [7:0] A_IE = 8'h00;
  localparam logic [7:0] A_ST = 8'h04;
  function automatic logic [7:0] a_ctl(int n); return 8'(32*n + 16); endfunction
  function automatic logic [7:0] a_ilo(int n); return 8'(32*n + 20); endfunction
  function automatic logic [7:0] a_ihi(int n); return 8'(32*n + 24); endfunction
  function automatic logic [7:0] a_clo(int n); return 8'(32*n + 28); endfunction
  function automatic logic [7:0] a_chi(int n); return 8'(32*n + 32); endfunction
  function automatic logic [31:0] ctl(bit os, int pre, bit rl, bit en);
    return {24'd0, os, 3'(pre), 2'b00, rl, en};
  endfunction
  function automatic int unsigned irq_edge(int unsigned t0, int unsigned n, int pre, int k);
    return t0 + 1 + 32'(k) * n * (32'd1 << pre) + 1;
  endfunction
  function automatic logic [63:0] cnt_at(logic [63:0] iv, int unsigned t0, int unsigned r, int pre);
    return iv - 64'((r - t0 - 2) >> pre);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  task automatic bwr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_irq(input int ch, input int unsigned lim, output int unsigned at);
    int unsigned k = 0;
    while (!irq[ch] && k < lim) begin @(negedge clk); k++; end
    at = ncyc;
  endtask

  task automatic stop_all();
    for (int c = 0; c < NCH; c++) bwr(a_ctl(c), 32'd0);
    bwr(A_ST, 32'hF);
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    #(CLK_P * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", ncyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rv;
    logic [63:0] ev;
    int unsigned t0, at, rnd;
    rnd = $urandom(32'd11);
    repeat (4) @(negedge clk);
    chk(irq == '0, "R1 irq during reset", 64'(irq), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(bus_rdata == 0, "R1 rdata after reset", 64'(bus_rdata), 0);
    brd(A_IE, rv); chk(rv == 0, "R1 ie reset", 64'(rv), 0);
    brd(A_ST, rv); chk(rv == 0, "R1 status reset", 64'(rv), 0);
    for (int c = 0; c < NCH; c++) begin
      brd(a_ctl(c), rv); chk(rv == 0, "R1 ctrl reset", 64'(rv), 0);
      brd(a_clo(c), rv); chk(rv == 0, "R1 count reset", 64'(rv), 0);
    end

    // R2/R3 address map and field layout
    bwr(a_ilo(3), 32'hA5A5_0003); bwr(a_ihi(3), 32'h0000_1234);
    brd(a_ilo(3), rv); chk(rv == 32'hA5A5_0003, "R2 ch3 interval low", 64'(rv), 64'hA5A50003);
    brd(a_ihi(3), rv); chk(rv == 32'h1234, "R2 ch3 interval high", 64'(rv), 64'h1234);
    bwr(a_ctl(2), 32'hFFFF_FFF0);
    brd(a_ctl(2), rv); chk(rv == 32'hF0, "R3 ctrl field layout", 64'(rv), 64'hF0);
    bwr(a_ctl(2), 32'd0);
    bwr(A_IE, 32'hFF);
    brd(A_IE, rv); chk(rv == 32'hF, "R2 ie width", 64'(rv), 64'hF);
    brd(8'h08, rv); chk(rv == 0, "R2 unmapped read", 64'(rv), 0);

    // R5/R6 periodic expiry timing
    bwr(a_ilo(0), 32'd10); bwr(a_ihi(0), 32'd0);
    bwr(a_ctl(0), ctl(0, 0, 1, 1)); t0 = ncyc;
    wait_irq(0, 200, at);
    chk(at == irq_edge(t0, 10, 0, 1), "R5 first expiry edge", 64'(at), 64'(irq_edge(t0, 10, 0, 1)));
    bwr(A_ST, 32'h1); @(negedge clk);
    chk(irq[0] == 1'b0, "R10 irq low after clear", 64'(irq[0]), 0);
    wait_irq(0, 200, at);
    chk(at == irq_edge(t0, 10, 0, 2), "R6 periodic second expiry", 64'(at), 64'(irq_edge(t0, 10, 0, 2)));
    stop_all();

    // R4 counting with prescale 4, all-ones interval
    bwr(a_ilo(1), 32'hFFFF_FFFF); bwr(a_ihi(1), 32'hFFFF_FFFF);
    bwr(a_ctl(1), ctl(0, 2, 1, 1)); t0 = ncyc;
    @(negedge clk);
    for (int j = 0; j < 3; j++) begin
      repeat (j * 5) @(negedge clk);
      brd(a_clo(1), rv);
      ev = cnt_at(64'hFFFF_FFFF_FFFF_FFFF, t0, ncyc, 2);
      chk(rv == ev[31:0], "R4 decreasing count low", 64'(rv), 64'(ev[31:0]));
    end
    brd(a_chi(1), rv); chk(rv == 32'hFFFF_FFFF, "R12 high word", 64'(rv), 64'hFFFFFFFF);
    stop_all();

    // R12 snapshot across a borrow
    bwr(a_ilo(1), 32'd0); bwr(a_ihi(1), 32'd1);
    bwr(a_ctl(1), ctl(0, 0, 1, 1)); t0 = ncyc;
    @(negedge clk);
    brd(a_clo(1), rv); chk(rv == 0, "R12 low at snapshot", 64'(rv), 0);
    brd(a_chi(1), rv); chk(rv == 1, "R12 high from snapshot", 64'(rv), 1);
    stop_all();

    // R7 one-shot
    bwr(a_ilo(2), 32'd5); bwr(a_ihi(2), 32'd0);
    bwr(a_ctl(2), ctl(1, 1, 1, 1)); t0 = ncyc;
    wait_irq(2, 200, at);
    chk(at == irq_edge(t0, 5, 1, 1), "R5 one-shot expiry edge", 64'(at), 64'(irq_edge(t0, 5, 1, 1)));
    brd(a_ctl(2), rv); chk(rv == 32'h90, "R7 enable cleared", 64'(rv), 64'h90);
    brd(a_clo(2), rv); chk(rv == 0, "R7 count parked at zero", 64'(rv), 0);
    bwr(A_ST, 32'h4);
    repeat (30) @(negedge clk);
    brd(A_ST, rv); chk(rv == 0, "R7 no further expiry", 64'(rv), 0);
    chk(irq == '0, "R7 irq stays low", 64'(irq), 0);

    // R8 reload
    bwr(a_ilo(3), 32'd50); bwr(a_ihi(3), 32'd0);
    bwr(a_ctl(3), ctl(0, 0, 1, 1)); t0 = ncyc;
    @(negedge clk);
    brd(a_ctl(3), rv); chk(rv == 32'h1, "R8 reload self-clears", 64'(rv), 1);
    bwr(a_ilo(3), 32'd40);
    brd(a_clo(3), rv); ev = cnt_at(64'd50, t0, ncyc, 0);
    chk(rv == ev[31:0], "R8 interval write leaves count", 64'(rv), 64'(ev[31:0]));
    bwr(a_ctl(3), ctl(0, 0, 1, 1));
    @(negedge clk);
    brd(a_clo(3), rv); chk(rv == 40, "R8 reload copies interval", 64'(rv), 40);

    // R9 stop window
    bwr(a_ctl(3), 32'd0);
    bwr(a_ctl(3), ctl(0, 0, 0, 1));
    brd(a_ctl(3), rv); chk(rv == 0, "R9 re-enable next cycle ignored", 64'(rv), 0);
    bwr(a_ctl(3), ctl(0, 0, 0, 1));
    brd(a_ctl(3), rv); chk(rv == 1, "R9 re-enable third cycle accepted", 64'(rv), 1);
    bwr(a_ctl(3), 32'd0);
    @(negedge clk);
    bwr(a_ctl(3), ctl(0, 0, 0, 1));
    brd(a_ctl(3), rv); chk(rv == 0, "R9 re-enable second cycle ignored", 64'(rv), 0);
    stop_all();

    // R10 clear versus concurrent expiry
    bwr(a_ilo(0), 32'd6); bwr(a_ihi(0), 32'd0);
    bwr(a_ctl(0), ctl(1, 0, 1, 1)); t0 = ncyc;
    while (ncyc < t0 + 6) @(negedge clk);
    bwr(A_ST, 32'h1);
    brd(A_ST, rv); chk(rv[0] == 1'b1, "R10 expiry wins over clear", 64'(rv[0]), 1);
    bwr(A_ST, 32'h0);
    brd(A_ST, rv); chk(rv[0] == 1'b1, "R10 zero write keeps bit", 64'(rv[0]), 1);
    bwr(A_ST, 32'h1);
    brd(A_ST, rv); chk(rv[0] == 1'b0, "R10 one clears bit", 64'(rv[0]), 0);
    stop_all();

    // R11 masking and lag
    bwr(A_IE, 32'h0);
    bwr(a_ilo(1), 32'd4); bwr(a_ihi(1), 32'd0);
    bwr(a_ctl(1), ctl(1, 0, 1, 1));
    repeat (20) @(negedge clk);
    chk(irq[1] == 1'b0, "R11 masked irq low", 64'(irq[1]), 0);
    brd(A_ST, rv); chk(rv[1] == 1'b1, "R11 status set while masked", 64'(rv[1]), 1);
    bwr(A_IE, 32'h2);
    chk(irq[1] == 1'b0, "R11 irq lags enable", 64'(irq[1]), 0);
    @(negedge clk);
    chk(irq[1] == 1'b1, "R11 irq after enable", 64'(irq[1]), 1);
    stop_all();
    bwr(A_IE, 32'hF);

    // R4 largest prescale
    bwr(a_ilo(2), 32'd3); bwr(a_ihi(2), 32'd0);
    bwr(a_ctl(2), ctl(1, 7, 1, 1)); t0 = ncyc;
    wait_irq(2, 1000, at);
    chk(at == irq_edge(t0, 3, 7, 1), "R4 prescale 128 expiry", 64'(at), 64'(irq_edge(t0, 3, 7, 1)));
    stop_all();

    // random mix, R5 and R6
    for (int it = 0; it < 14; it++) begin
      int ch, pre;
      int unsigned n;
      bit os;
      ch  = int'($urandom % NCH);
      n   = 3 + ($urandom % 14);
      pre = int'($urandom % 4);
      os  = 1'($urandom % 2);
      bwr(a_ilo(ch), n); bwr(a_ihi(ch), 32'd0);
      bwr(a_ctl(ch), ctl(os, pre, 1, 1)); t0 = ncyc;
      wait_irq(ch, 3 * n * (32'd1 << pre) + 20, at);
      chk(at == irq_edge(t0, n, pre, 1), "R5 random expiry edge", 64'(at), 64'(irq_edge(t0, n, pre, 1)));
      if (os) begin
        brd(a_ctl(ch), rv);
        chk(rv[0] == 1'b0, "R7 random one-shot enable", 64'(rv[0]), 0);
      end else begin
        bwr(A_ST, 32'h1 << ch);
        @(negedge clk);
        wait_irq(ch, 3 * n * (32'd1 << pre) + 20, at);
        chk(at == irq_edge(t0, n, pre, 2), "R6 random period", 64'(at), 64'(irq_edge(t0, n, pre, 2)));
      end
      stop_all();
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule